// File: doc/BRIEF.md
# Security-Banked Control Register Unit

This block holds the CONTROL state of a small processor core that runs in a secure or a non-secure state, each at a privileged or unprivileged level. It sits behind the system-register move instructions. There is a combinational read port and a clocked write port, and both are addressed by an 8-bit register number. The write request also carries a 4-bit mask. Two register numbers are served: the CONTROL view of the current state (20), and an alias that lets secure code reach the non-secure copy (0x94). All other numbers read as zero and have no effect when written.

Each security state has its own copy of the stack-select bit and the unprivileged-thread bit. The two floating-point context bits are kept once, in the secure copy, and the read views merge them in. Each bit follows its own write rule. The rule depends on the security state, the privilege, handler or thread mode, a set of feature straps and one coprocessor access-control bit.

Top module: `sec_ctrl_regfile`

## Requirements
- R1: After reset, both copies are cleared, so every read of either register number returns 0.
- R2: The bit layout is nPRIV at bit 0, SPSEL at bit 1, FPCA at bit 2 and SFPA at bit 3. Higher bits read as 0. Register numbers other than 20 and 0x94 read as 0 and change nothing when written.
- R3: A read of 20 from secure state returns the secure copy. From non-secure state it returns the non-secure nPRIV and SPSEL, the FPCA bit taken from the secure copy, and SFPA as 0.
- R4: A read of 0x94 returns 0 from non-secure state. From secure state it returns the non-secure nPRIV and SPSEL together with the FPCA bit from the secure copy.
- R5: When the FPU strap is low, FPCA and SFPA read as 0 in every view, and writes leave them unchanged.
- R6: A write to 20 updates nPRIV of the current state's copy only when the writer is privileged and the main-extension strap is high.
- R7: A write to 20 updates SPSEL of the current state's copy only when the writer is privileged and either the v8 strap is high or the core is in thread mode.
- R8: A write to 20 updates SFPA only when the FPU is present and the state is secure. The write may come from unprivileged code.
- R9: A write to 20 updates FPCA only when the FPU is present, the writer is privileged, and at least one of these holds: the state is secure, the security-extension strap is low, or the access-control bit is high.
- R10: A privileged secure write to 0x94 updates the non-secure nPRIV and leaves the non-secure SPSEL alone. It updates FPCA only when the FPU is present and the access-control bit is high.
- R11: Writes to 0x94 that are unprivileged or made from non-secure state are ignored.
- R12: The mask in bits [11:8] of the write request has no effect on a CONTROL write. The register number is in bits [7:0].
- R13: A write takes effect at the rising clock edge. A read reflects the stored state and the current inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| isSecure | input | 1 | Current security state is secure |
| isPriv | input | 1 | Current code is privileged |
| isHandler | input | 1 | Core is in handler mode (0 means thread mode) |
| hasFpu | input | 1 | FPU present strap |
| hasSecExt | input | 1 | Security extension present strap |
| hasMainExt | input | 1 | Main extension present strap |
| v8Mode | input | 1 | v8 write behaviour strap |
| nsFpAccess | input | 1 | Access-control bit that grants non-secure FP access |
| wrEn | input | 1 | Write request valid |
| wrReq | input | 12 | Write mask [11:8] and register number [7:0] |
| wrData | input | DATA_W | Write value |
| rdNum | input | 8 | Read register number |
| rdData | output | DATA_W | Read value |

## Verification
Random writes and reads are made under every combination of security state, privilege, mode, strap and access-control bit. The bench tracks the result in its own model of the two copies. This separates bits that are stored per state from the shared FP bits: for example, a non-secure write to FPCA appears in the secure view. Directed cases isolate each write rule one at a time. These cover an unprivileged secure SFPA write, handler mode with and without v8 behaviour, a missing main extension, non-secure FPCA with the access bit on and off, and alias writes from each state and level. They also show that mask bits, high data bits and unknown register numbers change nothing, and that a write does not appear before its clock edge.

// File: rtl/secctl_pkg.sv
package secctl_pkg;
  localparam int NUM_W   = 8;
  localparam int MASK_W  = 4;
  localparam int REQ_W   = NUM_W + MASK_W;
  localparam int BANKS   = 2;   // index 1 = secure copy, 0 = non-secure copy
  localparam logic [NUM_W-1:0] NUM_CONTROL    = 8'd20;
  localparam logic [NUM_W-1:0] NUM_CONTROL_NS = 8'h94;
  localparam logic [NUM_W-1:0] NUM_STATUS_MAX = 8'd7;

  localparam int BIT_NPRIV = 0;
  localparam int BIT_SPSEL = 1;
  localparam int BIT_FPCA  = 2;
  localparam int BIT_SFPA  = 3;

  typedef struct packed {
    logic sfpa;
    logic fpca;
    logic spsel;
    logic npriv;
  } ctlBits_t;

  localparam int CTL_W = $bits(ctlBits_t);

  typedef enum logic [1:0] {
    VIEW_ZERO,
    VIEW_OWN_S,
    VIEW_OWN_NS,
    VIEW_ALIAS
  } rdView_t;

  typedef struct packed {
    logic bankSec;
    logic setNpriv;
    logic setSpsel;
    logic setFpca;
    logic setSfpa;
  } wrStrobe_t;
endpackage

// File: rtl/secctl_ctrl.sv
module secctl_ctrl
  import secctl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             isSecure,
  input  logic             isPriv,
  input  logic             isHandler,
  input  logic             hasFpu,
  input  logic             hasSecExt,
  input  logic             hasMainExt,
  input  logic             v8Mode,
  input  logic             nsFpAccess,
  input  logic             wrEn,
  input  logic [REQ_W-1:0] wrReq,
  input  logic [NUM_W-1:0] rdNum,
  output wrStrobe_t        strobe,
  output rdView_t          view
);
  logic [NUM_W-1:0]  wrNum;
  logic [MASK_W-1:0] unusedMask;
  logic privOk;
  logic hitCtl;
  logic hitAlias;

  assign wrNum      = wrReq[NUM_W-1:0];
  assign unusedMask = wrReq[REQ_W-1:NUM_W];

  // unprivileged code may reach only the status sub-fields and CONTROL
  assign privOk   = isPriv || (wrNum <= NUM_STATUS_MAX) || (wrNum == NUM_CONTROL);
  assign hitCtl   = wrEn && privOk && (wrNum == NUM_CONTROL);
  assign hitAlias = wrEn && privOk && (wrNum == NUM_CONTROL_NS) && isSecure;

  always_comb begin
    strobe = '0;
    if (hitCtl) begin
      strobe.bankSec  = isSecure;
      strobe.setSpsel = isPriv && (v8Mode || !isHandler);
      strobe.setNpriv = isPriv && hasMainExt;
      strobe.setSfpa  = hasFpu && isSecure;
      strobe.setFpca  = hasFpu && isPriv && (isSecure || !hasSecExt || nsFpAccess);
    end else if (hitAlias) begin
      strobe.bankSec  = 1'b0;
      strobe.setNpriv = 1'b1;
      strobe.setFpca  = hasFpu && nsFpAccess;
    end
  end

  always_comb begin
    unique case (rdNum)
      NUM_CONTROL:    view = isSecure ? VIEW_OWN_S : VIEW_OWN_NS;
      NUM_CONTROL_NS: view = isSecure ? VIEW_ALIAS : VIEW_ZERO;
      default:        view = VIEW_ZERO;
    endcase
  end

  // R8
  sfpa_ns_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !isSecure |-> !strobe.setSfpa);

  // R5
  nofpu_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hasFpu |-> (!strobe.setFpca && !strobe.setSfpa));

  // R11
  alias_ns_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!isSecure && wrNum == NUM_CONTROL_NS) |-> (strobe == '0));

  // R6
  unpriv_npriv_chk: assert property (@(posedge clk) disable iff (!rstN)
    !isPriv |-> (!strobe.setNpriv && !strobe.setSpsel && !strobe.setFpca));
endmodule

// File: rtl/secctl_store.sv
module secctl_store
  import secctl_pkg::*;
#(
  parameter int DATA_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strobe,
  input  rdView_t           view,
  input  logic              fpVisible,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  ctlBits_t wrBits;
  logic [DATA_W-CTL_W-1:0] unusedHi;
  logic [BANKS-1:0] nprivQ;
  logic [BANKS-1:0] spselQ;
  logic fpcaQ;
  logic sfpaQ;
  logic fpcaVis;
  logic sfpaVis;
  ctlBits_t outBits;

  assign wrBits   = wrData[CTL_W-1:0];
  assign unusedHi = wrData[DATA_W-1:CTL_W];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    localparam logic SEL = (b == 1);
    logic nprivR;
    logic spselR;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        nprivR <= 1'b0;
        spselR <= 1'b0;
      end else if (strobe.bankSec == SEL) begin
        if (strobe.setNpriv) nprivR <= wrBits.npriv;
        if (strobe.setSpsel) spselR <= wrBits.spsel;
      end
    end
    assign nprivQ[b] = nprivR;
    assign spselQ[b] = spselR;
  end

  // floating-point context bits exist only in the secure copy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fpcaQ <= 1'b0;
      sfpaQ <= 1'b0;
    end else begin
      if (strobe.setFpca) fpcaQ <= wrBits.fpca;
      if (strobe.setSfpa) sfpaQ <= wrBits.sfpa;
    end
  end

  assign fpcaVis = fpVisible & fpcaQ;
  assign sfpaVis = fpVisible & sfpaQ;

  always_comb begin
    outBits = '0;
    unique case (view)
      VIEW_OWN_S: begin
        outBits.sfpa  = sfpaVis;
        outBits.fpca  = fpcaVis;
        outBits.spsel = spselQ[1];
        outBits.npriv = nprivQ[1];
      end
      VIEW_OWN_NS, VIEW_ALIAS: begin
        outBits.fpca  = fpcaVis;
        outBits.spsel = spselQ[0];
        outBits.npriv = nprivQ[0];
      end
      default: outBits = '0;
    endcase
  end

  assign rdData = DATA_W'(outBits);

  // R8
  sfpa_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.setSfpa |=> $stable(sfpaQ));

  // R9
  fpca_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.setFpca |=> $stable(fpcaQ));

  // R6
  npriv_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.setNpriv |=> ($stable(nprivQ[0]) && $stable(nprivQ[1])));

  // R5
  nofpu_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fpVisible |-> (rdData[BIT_FPCA] == 1'b0 && rdData[BIT_SFPA] == 1'b0));
endmodule

// File: rtl/sec_ctrl_regfile.sv
module sec_ctrl_regfile
  import secctl_pkg::*;
#(
  parameter int DATA_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              isSecure,
  input  logic              isPriv,
  input  logic              isHandler,
  input  logic              hasFpu,
  input  logic              hasSecExt,
  input  logic              hasMainExt,
  input  logic              v8Mode,
  input  logic              nsFpAccess,
  input  logic              wrEn,
  input  logic [11:0]       wrReq,
  input  logic [DATA_W-1:0] wrData,
  input  logic [7:0]        rdNum,
  output logic [DATA_W-1:0] rdData
);
  wrStrobe_t strobe;
  rdView_t   view;

  secctl_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .isSecure(isSecure), .isPriv(isPriv), .isHandler(isHandler),
    .hasFpu(hasFpu), .hasSecExt(hasSecExt), .hasMainExt(hasMainExt),
    .v8Mode(v8Mode), .nsFpAccess(nsFpAccess),
    .wrEn(wrEn), .wrReq(wrReq), .rdNum(rdNum),
    .strobe(strobe), .view(view)
  );

  secctl_store #(.DATA_W(DATA_W)) store_i (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .view(view), .fpVisible(hasFpu),
    .wrData(wrData), .rdData(rdData)
  );

  // R4
  alias_ns_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdNum == NUM_CONTROL_NS && !isSecure) |-> (rdData == '0));

  // R2
  other_num_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdNum != NUM_CONTROL && rdNum != NUM_CONTROL_NS) |-> (rdData == '0));

  // R3
  ns_view_sfpa_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdNum == NUM_CONTROL && !isSecure) |-> (rdData[BIT_SFPA] == 1'b0));
endmodule

// File: tb/sec_ctrl_regfile_tb.sv
`timescale 1ns/1ps
module sec_ctrl_regfile_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic isSecure = 0, isPriv = 0, isHandler = 0, hasFpu = 0;
  logic hasSecExt = 0, hasMainExt = 0, v8Mode = 0, nsFpAccess = 0;
  logic wrEn = 0;
  logic [11:0] wrReq = '0;
  logic [31:0] wrData = '0;
  logic [7:0]  rdNum = '0;
  logic [31:0] rdData;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [3:0] mS;   // model of secure copy {sfpa,fpca,spsel,npriv}
  logic [1:0] mNs;  // model of non-secure copy {spsel,npriv}

  always #10 clk = ~clk;

  sec_ctrl_regfile dut_i (
    .clk(clk), .rstN(rstN),
    .isSecure(isSecure), .isPriv(isPriv), .isHandler(isHandler),
    .hasFpu(hasFpu), .hasSecExt(hasSecExt), .hasMainExt(hasMainExt),
    .v8Mode(v8Mode), .nsFpAccess(nsFpAccess),
    .wrEn(wrEn), .wrReq(wrReq), .wrData(wrData),
    .rdNum(rdNum), .rdData(rdData)
  );

  function automatic logic [31:0] expRead(input logic [7:0] num);
    logic fpc, sfp;
    fpc = hasFpu & mS[2];
    sfp = hasFpu & mS[3];
    if (num == 8'd20)
      return isSecure ? {28'd0, sfp, fpc, mS[1:0]} : {28'd0, 1'b0, fpc, mNs};
    if (num == 8'h94)
      return isSecure ? {28'd0, 1'b0, fpc, mNs} : 32'd0;
    return 32'd0;
  endfunction

  function automatic void modelWrite(input logic [7:0] num, input logic [31:0] val);
    if (num == 8'd20) begin
      if (isPriv && (v8Mode || !isHandler)) begin
        if (isSecure) mS[1] = val[1]; else mNs[1] = val[1];
      end
      if (isPriv && hasMainExt) begin
        if (isSecure) mS[0] = val[0]; else mNs[0] = val[0];
      end
      if (hasFpu && isSecure) mS[3] = val[3];
      if (hasFpu && isPriv && (isSecure || !hasSecExt || nsFpAccess)) mS[2] = val[2];
    end else if (num == 8'h94 && isSecure && isPriv) begin
      mNs[0] = val[0];
      if (hasFpu && nsFpAccess) mS[2] = val[2];
    end
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic setEnv(input logic sec, input logic priv, input logic hand, input logic fpu,
                        input logic sx, input logic mx, input logic v8, input logic acc);
    @(negedge clk);
    isSecure = sec; isPriv = priv; isHandler = hand; hasFpu = fpu;
    hasSecExt = sx; hasMainExt = mx; v8Mode = v8; nsFpAccess = acc;
  endtask

  task automatic doWrite(input logic [7:0] num, input logic [3:0] msk, input logic [31:0] val);
    @(negedge clk);
    wrEn = 1'b1; wrReq = {msk, num}; wrData = val;
    modelWrite(num, val);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic checkRead(input logic [7:0] num, input string tag);
    rdNum = num;
    #1;
    chk(tag, rdData, expRead(num));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    mS = '0; mNs = '0;
    // R1: reset state
    isSecure = 1; hasFpu = 1;
    repeat (2) @(negedge clk);
    rdNum = 8'd20; #1; chk("R1 reset ctl", rdData, 32'd0);
    rdNum = 8'h94; #1; chk("R1 reset alias", rdData, 32'd0);
    rstN = 1'b1;

    // secure privileged, full write (R6 R7 R8 R9)
    setEnv(1, 1, 0, 1, 1, 1, 0, 0);
    doWrite(8'd20, 4'h0, 32'h0000_000F);
    checkRead(8'd20, "R9 secure full write");
    rdNum = 8'd20; #1; chk("R2 layout literal", rdData, 32'h0000_000F);
    checkRead(8'd99, "R2 other num");
    doWrite(8'd20, 4'h0, 32'hFFFF_FFF5);
    rdNum = 8'd20; #1; chk("R2 high bits zero", rdData, 32'h0000_0005);

    // R13: write not visible before edge
    @(negedge clk);
    wrEn = 1; wrReq = {4'h0, 8'd20}; wrData = 32'h0; rdNum = 8'd20;
    #1; chk("R13 before edge", rdData, 32'h0000_0005);
    modelWrite(8'd20, 32'h0);
    @(negedge clk); wrEn = 0;
    checkRead(8'd20, "R13 after edge");

    // non-secure privileged (R3): FPCA blocked, SFPA blocked
    setEnv(1, 1, 0, 1, 1, 1, 0, 0);
    doWrite(8'd20, 4'h0, 32'h0000_000C);
    setEnv(0, 1, 0, 1, 1, 1, 0, 0);
    doWrite(8'd20, 4'h0, 32'h0000_0003);
    checkRead(8'd20, "R3 ns view");
    rdNum = 8'd20; #1; chk("R3 ns literal", rdData, 32'h0000_0007);
    doWrite(8'd20, 4'h0, 32'h0000_0000);
    checkRead(8'd20, "R9 ns fpca blocked");
    checkRead(8'h94, "R4 alias from ns");
    setEnv(1, 1, 0, 1, 1, 1, 0, 0);
    checkRead(8'h94, "R4 alias from s");
    checkRead(8'd20, "R8 sfpa kept after ns write");

    // R8: unprivileged secure clears SFPA only
    setEnv(1, 1, 0, 1, 1, 1, 0, 0);
    doWrite(8'd20, 4'h0, 32'h0000_000F);
    setEnv(1, 0, 0, 1, 1, 1, 0, 0);
    doWrite(8'd20, 4'h0, 32'h0000_0000);
    rdNum = 8'd20; #1; chk("R8 unpriv sfpa", rdData, 32'h0000_0007);

    // R7: handler without v8 blocks SPSEL; with v8 allows
    setEnv(1, 1, 1, 1, 1, 1, 0, 0);
    doWrite(8'd20, 4'h0, 32'h0000_0005);
    checkRead(8'd20, "R7 handler v7 blocked");
    setEnv(1, 1, 1, 1, 1, 1, 1, 0);
    doWrite(8'd20, 4'h0, 32'h0000_0005);
    rdNum = 8'd20; #1; chk("R7 handler v8", rdData, 32'h0000_0005);

    // R6: no main extension blocks nPRIV
    setEnv(1, 1, 0, 1, 1, 0, 0, 0);
    doWrite(8'd20, 4'h0, 32'h0000_0004);
    checkRead(8'd20, "R6 no main");

    // R9: ns with access bit, and without security extension
    setEnv(0, 1, 0, 1, 1, 1, 0, 1);
    doWrite(8'd20, 4'h0, 32'h0000_0000);
    checkRead(8'd20, "R9 ns acc set");
    setEnv(0, 1, 0, 1, 0, 1, 0, 0);
    doWrite(8'd20, 4'h0, 32'h0000_0004);
    checkRead(8'd20, "R9 no sec ext");

    // R10: secure alias writes
    setEnv(1, 1, 0, 1, 1, 1, 0, 0);
    doWrite(8'h94, 4'h0, 32'h0000_0003);
    checkRead(8'h94, "R10 alias npriv no acc");
    setEnv(1, 1, 0, 1, 1, 1, 0, 1);
    doWrite(8'h94, 4'h0, 32'h0000_0000);
    checkRead(8'h94, "R10 alias fpca acc");

    // R11: ignored alias writes
    setEnv(1, 0, 0, 1, 1, 1, 0, 1);
    doWrite(8'h94, 4'h0, 32'h0000_0007);
    setEnv(0, 1, 0, 1, 1, 1, 0, 1);
    doWrite(8'h94, 4'h0, 32'h0000_0007);
    setEnv(1, 1, 0, 1, 1, 1, 0, 1);
    checkRead(8'h94, "R11 alias ignored");
    doWrite(8'd5, 4'hF, 32'hFFFF_FFFF);
    checkRead(8'd20, "R2 write other num");

    // R12: mask irrelevant
    doWrite(8'd20, 4'hF, 32'h0000_000A);
    checkRead(8'd20, "R12 mask F");
    doWrite(8'd20, 4'h3, 32'h0000_0005);
    checkRead(8'd20, "R12 mask 3");

    // R5: no FPU
    setEnv(1, 1, 0, 0, 1, 1, 0, 1);
    doWrite(8'd20, 4'h0, 32'h0000_000A);
    rdNum = 8'd20; #1; chk("R5 nofpu read", rdData & 32'hC, 32'h0);
    checkRead(8'd20, "R5 nofpu model");
    setEnv(1, 1, 0, 1, 1, 1, 0, 1);
    checkRead(8'd20, "R5 fp bits held");

    // random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] num;
      logic [31:0] r;
      r = $urandom;
      setEnv(r[0], r[1], r[2], r[3], r[4], r[5], r[6], r[7]);
      case (r[9:8])
        2'd0, 2'd1: num = 8'd20;
        2'd2: num = 8'h94;
        default: num = 8'($urandom);
      endcase
      doWrite(num, 4'($urandom), $urandom);
      r = $urandom;
      isSecure = r[0]; hasFpu = r[1] | r[2];
      case (r[5:4])
        2'd0, 2'd1: checkRead(8'd20, "R3 random");
        2'd2: checkRead(8'h94, "R4 random");
        default: checkRead(8'($urandom), "R2 random");
      endcase
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule